// File: doc/BRIEF.md
# Zero-Turnaround Pipelined Burst SRAM

This block is a synchronous single-port SRAM of 36-bit words that keeps the data bus busy on every cycle, whatever mix of reads and writes it carries. Each command is captured on a rising clock edge. Its data phase follows two edges later. For a read, the word is registered onto `rdata`. For a write, the data and lane enables are sampled from the pins. Because the data phase of a read and the data phase of a write sit at the same pipeline depth, a write can follow a read and a read can follow a write on consecutive cycles without an idle cycle.

A small sequencer holds the current operation. It has three states: IDLE (deselected), READ and WRITE. On a load cycle it takes one of three transitions, chosen by the chip selects and the read/write select: load-deselect, load-read or load-write. On a continue cycle it takes the advance-hold transition, which keeps the same state while a 2-bit counter walks the low address bits in linear or interleaved order. Written data waits one cycle in a pending buffer before it reaches the array. A read that hits the pending address gets the new bytes through a bypass path.

Top module: `zt_sram`

## Requirements
- R1: After reset, `rvalid` and `rdata` are 0 until a read completes its data phase, and any continue cycle before the first load is a deselect.
- R2: A read loaded on edge k drives `rvalid` high and `rdata` with the addressed word right after edge k+2, and at no other time.
- R3: With `burst_cont` low, the cycle uses `addr`, `rd_nwr` and the three selects sampled on that edge, and it restarts the burst count at 0.
- R4: With `burst_cont` high, the cycle repeats the previous operation (read, write or deselect). On that cycle `addr`, `rd_nwr` and the selects have no effect.
- R5: With `order_xor` low, the low two address bits of the n-th cycle of a burst (n = 0..3, wrapping) equal start+n mod 4. The upper address bits stay fixed.
- R6: With `order_xor` high, the low two address bits of the n-th cycle equal start XOR n. The upper address bits stay fixed.
- R7: `rd_nwr` = 1 selects a read and `rd_nwr` = 0 selects a write. A write never raises `rvalid`.
- R8: For a write loaded on edge k, `wdata` and `lane_we_n` are sampled on edge k+2. Lane i is bits [9i+8:9i] and is gated by `lane_we_n[i]` (active low). A lane whose enable is high keeps its stored bytes.
- R9: A load is active only when `sel_n` is 0, `sel_b` equals `sel_b_hi` and `sel_c` equals `sel_c_hi`. Otherwise the cycle is a deselect: nothing is written, and `rvalid` is low two edges later.
- R10: Any sequence of reads and writes, in any order, runs one command per clock with no idle cycle between them.
- R11: A read of an address whose write data arrived one edge earlier returns the newly written lanes merged with the stored word.
- R12: `rdata` keeps its last value on every edge that completes no read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset of the pipeline state |
| burst_cont | input | 1 | 0 = load a new command, 1 = continue the burst |
| rd_nwr | input | 1 | 1 = read, 0 = write (used on load cycles) |
| addr | input | AW | Word address (AW = log2 DEPTH) |
| wdata | input | 36 | Write data, sampled two edges after the write command |
| lane_we_n | input | 4 | Active-low write enable for each 9-bit lane |
| sel_n | input | 1 | Active-low chip select |
| sel_b | input | 1 | Chip select, active level given by sel_b_hi |
| sel_c | input | 1 | Chip select, active level given by sel_c_hi |
| sel_b_hi | input | 1 | Static strap: 1 = sel_b active high |
| sel_c_hi | input | 1 | Static strap: 1 = sel_c active high |
| order_xor | input | 1 | Static: 0 = linear burst, 1 = interleaved burst |
| rdata | output | 36 | Registered read data |
| rvalid | output | 1 | High on the cycle after a read's data phase |

## Verification
The sequencer assertions assume that `order_xor` stays constant within a burst and changes only on a load cycle. The straps `sel_b_hi` and `sel_c_hi` are treated the same way. The bench changes these inputs only on load cycles, and it holds every input for a whole cycle, driving them on the falling edge. The array is not reset, so the bench writes every address it will read before it issues the first read, and it keeps its addresses within the instantiated depth.

// File: rtl/zt_sram_pkg.sv
package zt_sram_pkg;

    typedef enum logic [1:0] {
        OP_IDLE  = 2'd0,
        OP_WRITE = 2'd1,
        OP_READ  = 2'd2
    } op_e;

    function automatic logic [1:0] burst_lo(input logic [1:0] start,
                                            input logic [1:0] step,
                                            input logic       use_xor);
        logic [1:0] r;
        if (use_xor) r = start ^ step;
        else         r = start + step;
        return r;
    endfunction

endpackage

// File: rtl/zt_burst_ctrl.sv
module zt_burst_ctrl
    import zt_sram_pkg::*;
#(
    parameter int AW = 10
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          burst_cont,
    input  logic          rd_nwr,
    input  logic [AW-1:0] ext_addr,
    input  logic          sel_n,
    input  logic          sel_b,
    input  logic          sel_c,
    input  logic          sel_b_hi,
    input  logic          sel_c_hi,
    input  logic          order_xor,
    output op_e           cyc_op,
    output logic [AW-1:0] cyc_addr
);

    op_e           st_q, st_d;
    logic [AW-1:0] base_q, base_d;
    logic [1:0]    cnt_q, cnt_d;
    logic [1:0]    lo_q, lo_d;
    logic          chip_on;

    assign chip_on = !sel_n && (sel_b == sel_b_hi) && (sel_c == sel_c_hi);

    // next-state logic
    always_comb begin
        st_d   = st_q;
        base_d = base_q;
        cnt_d  = cnt_q;
        if (!burst_cont) begin
            base_d = ext_addr;
            cnt_d  = 2'd0;
            unique case ({chip_on, rd_nwr})
                2'b10:   st_d = OP_WRITE;   // load-write
                2'b11:   st_d = OP_READ;    // load-read
                default: st_d = OP_IDLE;    // load-deselect
            endcase
        end else begin
            cnt_d = cnt_q + 2'd1;
            unique case (st_q)              // advance-hold
                OP_IDLE:  st_d = OP_IDLE;
                OP_READ:  st_d = OP_READ;
                OP_WRITE: st_d = OP_WRITE;
                default:  st_d = OP_IDLE;
            endcase
        end
        lo_d = burst_lo(base_d[1:0], cnt_d, order_xor);
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q   <= OP_IDLE;
            base_q <= '0;
            cnt_q  <= 2'd0;
            lo_q   <= 2'd0;
        end else begin
            st_q   <= st_d;
            base_q <= base_d;
            cnt_q  <= cnt_d;
            lo_q   <= lo_d;
        end
    end

    // outputs
    always_comb begin
        cyc_op   = st_q;
        cyc_addr = {base_q[AW-1:2], lo_q};
    end

    AST_LOAD_TAKES_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        !burst_cont |=> cyc_addr == $past(ext_addr));                              // R3
    AST_ADV_HOLDS_OP: assert property (@(posedge clk) disable iff (!rst_n)
        burst_cont |=> cyc_op == $past(cyc_op));                                   // R4
    AST_ADV_HOLDS_UPPER: assert property (@(posedge clk) disable iff (!rst_n)
        burst_cont |=> cyc_addr[AW-1:2] == $past(cyc_addr[AW-1:2]));               // R4
    AST_LINEAR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        burst_cont && !order_xor |=> cyc_addr[1:0] == $past(cyc_addr[1:0]) + 2'd1); // R5
    AST_XOR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        burst_cont && order_xor |=>
            (cyc_addr[1:0] ^ base_q[1:0]) == $past(cyc_addr[1:0] ^ base_q[1:0]) + 2'd1); // R6
    AST_DESEL_ON_SEL: assert property (@(posedge clk) disable iff (!rst_n)
        !burst_cont && sel_n |=> cyc_op == OP_IDLE);                               // R9

endmodule

// File: rtl/zt_lane_store.sv
module zt_lane_store #(
    parameter int DEPTH  = 1024,
    parameter int AW     = 10,
    parameter int LANES  = 4,
    parameter int LANE_W = 9
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr_go,
    input  logic                    rd_go,
    input  logic [AW-1:0]           addr,
    input  logic [LANES*LANE_W-1:0] wdata,
    input  logic [LANES-1:0]        lane_we_n,
    output logic [LANES*LANE_W-1:0] rdata,
    output logic                    rvalid
);

    localparam int W = LANES * LANE_W;

    logic [W-1:0]     mem [DEPTH];
    logic             pend_q;
    logic [AW-1:0]    pend_addr_q;
    logic [W-1:0]     pend_data_q;
    logic [LANES-1:0] pend_en_q;
    logic [W-1:0]     stored, commit_word, read_word;
    logic             hit;

    assign stored = mem[addr];
    assign hit    = pend_q && (pend_addr_q == addr);

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        assign commit_word[i*LANE_W +: LANE_W] = pend_en_q[i] ?
            pend_data_q[i*LANE_W +: LANE_W] : mem[pend_addr_q][i*LANE_W +: LANE_W];
        assign read_word[i*LANE_W +: LANE_W] = (hit && pend_en_q[i]) ?
            pend_data_q[i*LANE_W +: LANE_W] : stored[i*LANE_W +: LANE_W];
    end

    always_ff @(posedge clk) begin
        if (pend_q) mem[pend_addr_q] <= commit_word;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_q      <= 1'b0;
            pend_addr_q <= '0;
            pend_data_q <= '0;
            pend_en_q   <= '0;
            rdata       <= '0;
            rvalid      <= 1'b0;
        end else begin
            pend_q <= wr_go;
            if (wr_go) begin
                pend_addr_q <= addr;
                pend_data_q <= wdata;
                pend_en_q   <= ~lane_we_n;
            end
            rvalid <= rd_go;
            if (rd_go) rdata <= read_word;
        end
    end

    AST_BYPASS_FRESH: assert property (@(posedge clk) disable iff (!rst_n)
        rd_go && hit && (&pend_en_q) |=> rdata == $past(pend_data_q));              // R11
    AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_go |=> $stable(rdata));                                                 // R12
    AST_ONE_OP: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_go && rd_go));                                                         // R10

endmodule

// File: rtl/zt_sram.sv
module zt_sram
    import zt_sram_pkg::*;
#(
    parameter int DEPTH  = 1024,
    parameter int LANES  = 4,
    parameter int LANE_W = 9,
    localparam int AW    = $clog2(DEPTH),
    localparam int W     = LANES * LANE_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          burst_cont,
    input  logic          rd_nwr,
    input  logic [AW-1:0] addr,
    input  logic [W-1:0]  wdata,
    input  logic [LANES-1:0] lane_we_n,
    input  logic          sel_n,
    input  logic          sel_b,
    input  logic          sel_c,
    input  logic          sel_b_hi,
    input  logic          sel_c_hi,
    input  logic          order_xor,
    output logic [W-1:0]  rdata,
    output logic          rvalid
);

    op_e           cyc_op;
    logic [AW-1:0] cyc_addr;
    op_e           op2_q;
    logic [AW-1:0] addr2_q;

    zt_burst_ctrl #(.AW(AW)) u_seq (
        .clk(clk), .rst_n(rst_n), .burst_cont(burst_cont), .rd_nwr(rd_nwr),
        .ext_addr(addr), .sel_n(sel_n), .sel_b(sel_b), .sel_c(sel_c),
        .sel_b_hi(sel_b_hi), .sel_c_hi(sel_c_hi), .order_xor(order_xor),
        .cyc_op(cyc_op), .cyc_addr(cyc_addr)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            op2_q   <= OP_IDLE;
            addr2_q <= '0;
        end else begin
            op2_q   <= cyc_op;
            addr2_q <= cyc_addr;
        end
    end

    zt_lane_store #(.DEPTH(DEPTH), .AW(AW), .LANES(LANES), .LANE_W(LANE_W)) u_store (
        .clk(clk), .rst_n(rst_n),
        .wr_go(op2_q == OP_WRITE), .rd_go(op2_q == OP_READ),
        .addr(addr2_q), .wdata(wdata), .lane_we_n(lane_we_n),
        .rdata(rdata), .rvalid(rvalid)
    );

    AST_READ_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        rvalid == ($past(cyc_op, 2) == OP_READ));                                   // R2
    AST_WRITE_NO_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        $past(cyc_op, 2) == OP_WRITE |-> !rvalid);                                  // R7

endmodule

// File: tb/zt_sram_test.sv
`timescale 1ns/1ps
module zt_sram_test;

    localparam int DEPTH = 64;
    localparam int AW = 6;

    logic clk = 0, rst_n = 0;
    logic burst_cont = 1, rd_nwr = 1, order_xor = 0;
    logic [AW-1:0] addr = '0;
    logic [35:0] wdata = '0;
    logic [3:0] lane_we_n = 4'hF;
    logic sel_n = 1, sel_b = 1, sel_c = 0, sel_b_hi = 1, sel_c_hi = 0;
    logic [35:0] rdata;
    logic rvalid;

    int checks = 0, bad = 0;
    bit done = 0;
    string req = "R1";
    bit part_lanes = 0;

    logic [35:0] mm [DEPTH];
    int m_op = 0, m_base = 0, m_cnt = 0;
    int q_op[$];
    int q_adr[$];
    logic exp_valid = 0;
    logic [35:0] exp_data = '0;

    always #2 clk = ~clk;

    zt_sram #(.DEPTH(DEPTH)) uut (
        .clk(clk), .rst_n(rst_n), .burst_cont(burst_cont), .rd_nwr(rd_nwr),
        .addr(addr), .wdata(wdata), .lane_we_n(lane_we_n), .sel_n(sel_n),
        .sel_b(sel_b), .sel_c(sel_c), .sel_b_hi(sel_b_hi), .sel_c_hi(sel_c_hi),
        .order_xor(order_xor), .rdata(rdata), .rvalid(rvalid)
    );

    // reference model: op codes 0 idle, 1 write, 2 read
    task automatic model_edge();
        int op, a, lo;
        if (q_op.size() == 2) begin
            op = q_op.pop_front();
            a  = q_adr.pop_front();
            if (op == 1)
                for (int l = 0; l < 4; l++)
                    if (!lane_we_n[l]) mm[a][l*9 +: 9] = wdata[l*9 +: 9];
            exp_valid = (op == 2);
            if (op == 2) exp_data = mm[a];
        end
        if (!burst_cont) begin
            if (!sel_n && sel_b == sel_b_hi && sel_c == sel_c_hi) m_op = rd_nwr ? 2 : 1;
            else m_op = 0;
            m_base = addr;
            m_cnt = 0;
        end else begin
            m_cnt = (m_cnt + 1) % 4;
        end
        lo = order_xor ? ((m_base % 4) ^ m_cnt) : ((m_base + m_cnt) % 4);
        q_op.push_back(m_op);
        q_adr.push_back((m_base / 4) * 4 + lo);
    endtask

    task automatic compare();
        checks++;
        if (rvalid !== exp_valid) begin
            bad++;
            $display("FAIL %s rvalid act=%0b exp=%0b t=%0t", req, rvalid, exp_valid, $time);
        end
        checks++;
        if (rdata !== exp_data) begin
            bad++;
            $display("FAIL %s rdata act=%h exp=%h t=%0t", req, rdata, exp_data, $time);
        end
    endtask

    // one clock: inputs already set at the falling edge
    task automatic step();
        wdata = {$urandom, $urandom} ;
        lane_we_n = part_lanes ? 4'($urandom) : 4'h0;
        @(posedge clk);
        model_edge();
        @(negedge clk);
        compare();
    endtask

    task automatic load(input bit rd, input int a);
        burst_cont = 0; rd_nwr = rd; addr = AW'(a);
        sel_n = 0; sel_b = sel_b_hi; sel_c = sel_c_hi;
        step();
    endtask

    task automatic cont(input int n);
        for (int i = 0; i < n; i++) begin
            burst_cont = 1;
            addr = AW'($urandom); rd_nwr = 1'($urandom);
            sel_n = 1'($urandom); sel_b = 1'($urandom); sel_c = 1'($urandom);
            step();
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            burst_cont = 0; sel_n = 1; addr = AW'($urandom); rd_nwr = 1'($urandom);
            step();
        end
    endtask

    task automatic summary();
        $display("test done: total=%0d bad=%0d", checks, bad);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            bad++;
            $display("FAIL watchdog expired");
            summary();
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < DEPTH; i++) mm[i] = '0;
        repeat (4) @(negedge clk);
        rst_n = 1;
        // R1: reset state, continue cycles before any load stay deselected
        req = "R1";
        compare();
        cont(4);

        // R7 R5: fill the array with linear write bursts
        req = "R7";
        order_xor = 0;
        for (int b = 0; b < DEPTH / 4; b++) begin
            load(0, b * 4);
            burst_burst_fill: cont(3);
        end
        idle(3);

        // R2 R3: single reads at assorted addresses
        req = "R2";
        for (int i = 0; i < 12; i++) begin
            load(1, (i * 23) % DEPTH);
            idle(1);
        end
        idle(3);

        // R5: linear bursts from unaligned starts, longer than four
        req = "R5";
        for (int s = 0; s < 4; s++) begin
            load(1, 20 + s);
            cont(5);
        end
        idle(3);

        // R6: interleaved bursts, reads and writes
        req = "R6";
        order_xor = 1;
        for (int s = 0; s < 4; s++) begin
            load(s % 2 == 0, 40 + s);
            cont(4);
        end
        for (int s = 0; s < 4; s++) begin
            load(1, 40 + s);
            cont(3);
        end
        idle(3);
        order_xor = 0;

        // R4: continue cycles with noise on address, select and direction pins
        req = "R4";
        load(0, 8); cont(6);
        load(1, 9); cont(6);
        idle(1); cont(5);
        idle(3);

        // R8: partial lane writes then read back
        req = "R8";
        part_lanes = 1;
        for (int i = 0; i < 10; i++) begin
            load(0, 30 + i % 4);
            load(1, 30 + i % 4);
        end
        idle(3);
        part_lanes = 0;

        // R9: chip select polarity straps and deselect loads
        req = "R9";
        for (int p = 0; p < 4; p++) begin
            sel_b_hi = p[0]; sel_c_hi = p[1];
            load(1, p + 1);
            load(0, p + 50);
            burst_cont = 0; rd_nwr = 0; addr = AW'(p + 50); sel_n = 0;
            sel_b = ~sel_b_hi; sel_c = sel_c_hi; step();
            burst_cont = 0; rd_nwr = 1; sel_b = sel_b_hi; sel_c = ~sel_c_hi; step();
            burst_cont = 0; rd_nwr = 0; sel_n = 1; sel_c = sel_c_hi; step();
            cont(2);
            load(1, p + 50);
        end
        sel_b_hi = 1; sel_c_hi = 0;
        idle(3);

        // R10 R11: back-to-back turnarounds on one address and on neighbours
        req = "R10";
        for (int i = 0; i < 16; i++) load(i % 2, 12 + (i / 2) % 3);
        req = "R11";
        for (int i = 0; i < 8; i++) begin
            load(0, 60);
            load(1, 60);
        end
        part_lanes = 1;
        for (int i = 0; i < 8; i++) begin
            load(0, 61);
            load(1, 61);
            load(1, 61);
        end
        part_lanes = 0;
        idle(3);

        // R12 and mixed traffic
        req = "R12";
        part_lanes = 1;
        for (int i = 0; i < 2000; i++) begin
            if ($urandom % 3 == 0) cont(1);
            else if ($urandom % 8 == 0) idle(1);
            else load(1'($urandom), int'($urandom % DEPTH));
        end
        idle(4);

        done = 1;
        summary();
        $finish;
    end

endmodule